// File: doc/BRIEF.md
# Bipolar Stepper Phase Sequencer

This block sequences the coil drive for a two-phase bipolar stepper motor. Each rising edge of a slow step clock moves it one position, in full-step or half-step mode and in either direction. For each of the four coil terminals it produces a high-side enable and a low-side enable. A terminal is therefore driven high, driven low or left floating. Terminals 1 and 2 form coil X, and terminals 3 and 4 form coil Y.

A bias-present input gates the whole block. While it is absent, every driver is off, step edges are ignored and the position is held at home. An idle-coil control picks what happens to the unpowered coil in the odd half-step positions: it either floats or has both ends pulled high. A home flag drives an open-drain line low while the drivers show the home pattern.

The step clock, direction, mode, idle control and bias inputs are asynchronous to the system clock. They pass through a synchronizer chain before they are used. The outputs are registered.

Top module: `stepper_phase_seq`

## Requirements
- R1: The position changes only on a rising edge of `step_clk`, as seen in the system clock domain. Holding `step_clk` high or low leaves the position and outputs unchanged. The direction and mode in effect are those present at that edge.
- R2: Drive encoding is per terminal, with bit 0 = terminal 1 through bit 3 = terminal 4. Coil X positive means `hi_en[0]`=1 and `lo_en[1]`=1. Coil X negative means `hi_en[1]`=1 and `lo_en[0]`=1. Coil Y uses bits 2 and 3 in the same way. With `half_mode`=0 and `dir_rev`=0, the position cycles A→B→C→D→A, where A = X+ Y+, B = X− Y+, C = X− Y− and D = X+ Y−. That gives hi/lo of 5/A, 6/9, A/5 and 9/6 in hex.
- R3: With `half_mode`=1, each step moves through eight positions. In between any two adjacent full-step positions there is a position in which the coil that changes polarity is idle. For `dir_rev`=0 the order is A, AB (X idle, Y+), B, BC (X−, Y idle), C, CD (X idle, Y−), D, DA (X+, Y idle). `dir_rev`=1 walks every order in reverse.
- R4: In full-step mode, a step taken from an in-between (idle-coil) position moves by one, to the adjacent full-step position in the chosen direction. A step from a full-step position moves by two.
- R5: In an idle-coil position with `half_mode`=1 and `idle_hold`=0, both enables of both terminals of the idle coil are 0.
- R6: In an idle-coil position with `half_mode`=1 and `idle_hold`=1, both terminals of the idle coil have the high-side enable set and the low-side enable clear.
- R7: `idle_hold` has no effect when `half_mode`=0. An idle coil seen in full-step mode floats.
- R8: `home_pull` is 1 only while the outputs show position A (hi=0101, lo=1010). It is 1 whenever that pattern is driven.
- R9: While `bias_ok`=0, all enables and `home_pull` are 0, step edges are ignored, and the position is forced to A. When `bias_ok` returns, the outputs show position A.
- R10: No terminal ever has its high-side and low-side enables set together.
- R11: The synchronous reset clears every enable and `home_pull` and sets the position to A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| step_clk | input | 1 | Asynchronous step clock; its rising edge advances the position |
| dir_rev | input | 1 | 0 walks the order forward, 1 walks it in reverse |
| half_mode | input | 1 | 0 selects full step, 1 selects half step |
| idle_hold | input | 1 | In half step, 1 pulls both ends of the idle coil high; 0 floats them |
| bias_ok | input | 1 | Bias-present sense; 0 turns off all drivers and presets to home |
| hi_en | output | 4 | High-side enables, bit 0 = terminal 1 |
| lo_en | output | 4 | Low-side enables, bit 0 = terminal 1 |
| home_pull | output | 1 | Pull-down enable of the open-drain home flag (1 = line pulled low) |

## Verification
The bench builds the block with the default two-stage synchronizer. It holds each input pattern for several system clocks, so the result does not depend on the exact latency. A vector table walks both directions in both modes, including the wrap through home and the idle-coil states with the idle control both high and low. It also covers the one-position full-step moves out of an odd state, and a mode switch made without a step. Directed tests then cover reset, and loss of bias with steps applied while it is gone.

// File: rtl/stepper_phase_pkg.sv
package stepper_phase_pkg;

  localparam int POS_W   = 3;
  localparam int N_TERM  = 4;

  typedef enum logic [1:0] {
    COIL_POS  = 2'd0,
    COIL_NEG  = 2'd1,
    COIL_IDLE = 2'd2
  } coil_e;

  typedef struct packed {
    logic [1:0] hi;
    logic [1:0] lo;
  } pair_drv_t;

  // Coil X (terminals 1/2) polarity at each half-step position.
  function automatic coil_e coil_x_of(input logic [POS_W-1:0] pos);
    coil_e c;
    case (pos)
      3'd0, 3'd6, 3'd7: c = COIL_POS;
      3'd2, 3'd3, 3'd4: c = COIL_NEG;
      default:          c = COIL_IDLE;
    endcase
    return c;
  endfunction

  // Coil Y (terminals 3/4) polarity at each half-step position.
  function automatic coil_e coil_y_of(input logic [POS_W-1:0] pos);
    coil_e c;
    case (pos)
      3'd0, 3'd1, 3'd2: c = COIL_POS;
      3'd4, 3'd5, 3'd6: c = COIL_NEG;
      default:          c = COIL_IDLE;
    endcase
    return c;
  endfunction

  // Map a coil polarity onto its two terminals (bit 0 = odd terminal).
  function automatic pair_drv_t pair_of(input coil_e c, input logic hold);
    pair_drv_t d;
    case (c)
      COIL_POS: begin d.hi = 2'b01; d.lo = 2'b10; end
      COIL_NEG: begin d.hi = 2'b10; d.lo = 2'b01; end
      default:  begin d.hi = hold ? 2'b11 : 2'b00; d.lo = 2'b00; end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/stepper_sync.sv
module stepper_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/stepper_pos.sv
module stepper_pos
  import stepper_phase_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en_s,
  input  logic             step_s,
  input  logic             dir_s,
  input  logic             half_s,
  output logic             step_rise,
  output logic [POS_W-1:0] idx
);

  logic             step_d;
  logic [POS_W-1:0] amt;
  logic [POS_W-1:0] idx_next;

  always_ff @(posedge clk) begin
    if (rst) step_d <= 1'b0;
    else     step_d <= step_s;
  end

  assign step_rise = step_s & ~step_d;

  // Half step, or full step out of an odd position: one; else two.
  always_comb begin
    if (half_s || idx[0]) amt = POS_W'(1);
    else                  amt = POS_W'(2);
    idx_next = dir_s ? (idx - amt) : (idx + amt);
  end

  always_ff @(posedge clk) begin
    if (rst || !en_s)    idx <= '0;
    else if (step_rise)  idx <= idx_next;
  end

endmodule

// File: rtl/stepper_drive.sv
module stepper_drive
  import stepper_phase_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en_s,
  input  logic              half_s,
  input  logic              hold_s,
  input  logic [POS_W-1:0]  idx,
  output logic [N_TERM-1:0] hi_en,
  output logic [N_TERM-1:0] lo_en,
  output logic              home_pull
);

  pair_drv_t drv_x, drv_y;
  logic      hold_eff;

  assign hold_eff = half_s & hold_s;

  always_comb begin
    drv_x = pair_of(coil_x_of(idx), hold_eff);
    drv_y = pair_of(coil_y_of(idx), hold_eff);
  end

  always_ff @(posedge clk) begin
    if (rst || !en_s) begin
      hi_en     <= '0;
      lo_en     <= '0;
      home_pull <= 1'b0;
    end else begin
      hi_en     <= {drv_y.hi, drv_x.hi};
      lo_en     <= {drv_y.lo, drv_x.lo};
      home_pull <= (idx == '0);
    end
  end

endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
  import stepper_phase_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_clk,
  input  logic              dir_rev,
  input  logic              half_mode,
  input  logic              idle_hold,
  input  logic              bias_ok,
  output logic [N_TERM-1:0] hi_en,
  output logic [N_TERM-1:0] lo_en,
  output logic              home_pull
);

  localparam int CTRL_W = 5;

  logic [CTRL_W-1:0] ctrl_raw, ctrl_s;
  logic              en_s, step_s, dir_s, half_s, hold_s;
  logic              step_rise;
  logic [POS_W-1:0]  idx;

  assign ctrl_raw = {bias_ok, step_clk, dir_rev, half_mode, idle_hold};
  assign {en_s, step_s, dir_s, half_s, hold_s} = ctrl_s;

  stepper_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (ctrl_raw),
    .dout(ctrl_s)
  );

  stepper_pos u_pos (
    .clk      (clk),
    .rst      (rst),
    .en_s     (en_s),
    .step_s   (step_s),
    .dir_s    (dir_s),
    .half_s   (half_s),
    .step_rise(step_rise),
    .idx      (idx)
  );

  stepper_drive u_drive (
    .clk      (clk),
    .rst      (rst),
    .en_s     (en_s),
    .half_s   (half_s),
    .hold_s   (hold_s),
    .idx      (idx),
    .hi_en    (hi_en),
    .lo_en    (lo_en),
    .home_pull(home_pull)
  );

endmodule

// File: rtl/stepper_phase_seq_chk.sv
module stepper_phase_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       en_s,
  input logic       step_rise,
  input logic [2:0] idx,
  input logic [3:0] hi_en,
  input logic [3:0] lo_en,
  input logic       home_pull
);

  p_move_cause_r1: assert property (@(posedge clk) disable iff (rst)
    (idx != $past(idx)) |-> ($past(step_rise) || !$past(en_s)));

  p_step_moves_r3: assert property (@(posedge clk) disable iff (rst)
    (step_rise && en_s) |=> (idx != $past(idx)));

  p_home_shape_r8: assert property (@(posedge clk) disable iff (rst)
    home_pull |-> (hi_en == 4'b0101 && lo_en == 4'b1010));

  p_off_no_bias_r9: assert property (@(posedge clk) disable iff (rst)
    !en_s |=> (hi_en == 4'b0000 && lo_en == 4'b0000 && !home_pull));

  p_no_shoot_r10: assert property (@(posedge clk) disable iff (rst)
    (hi_en & lo_en) == 4'b0000);

endmodule

bind stepper_phase_seq stepper_phase_seq_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .en_s     (en_s),
  .step_rise(step_rise),
  .idx      (idx),
  .hi_en    (hi_en),
  .lo_en    (lo_en),
  .home_pull(home_pull)
);

// File: tb/stepper_phase_seq_bench.sv
module stepper_phase_seq_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_clk = 1'b0;
  logic       dir_rev = 1'b0;
  logic       half_mode = 1'b0;
  logic       idle_hold = 1'b0;
  logic       bias_ok = 1'b0;
  logic [3:0] hi_en, lo_en;
  logic       home_pull;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  stepper_phase_seq #(.SYNC_STAGES(2)) u_stepper_phase_seq (
    .clk(clk), .rst(rst), .step_clk(step_clk), .dir_rev(dir_rev),
    .half_mode(half_mode), .idle_hold(idle_hold), .bias_ok(bias_ok),
    .hi_en(hi_en), .lo_en(lo_en), .home_pull(home_pull)
  );

  // Vector: [12] step, [11] dir_rev, [10] half_mode, [9] idle_hold,
  //         [8:5] expected hi, [4:1] expected lo, [0] expected home_pull
  localparam int NV = 25;
  localparam logic [12:0] VEC [NV] = '{
    {4'b1000, 4'h6, 4'h9, 1'b0},  // R2 A->B
    {4'b1000, 4'hA, 4'h5, 1'b0},  // R2 B->C
    {4'b1000, 4'h9, 4'h6, 1'b0},  // R2 C->D
    {4'b1000, 4'h5, 4'hA, 1'b1},  // R2 R8 wrap to A
    {4'b1100, 4'h9, 4'h6, 1'b0},  // R2 reverse A->D
    {4'b1010, 4'h1, 4'h2, 1'b0},  // R3 R5 D->DA float
    {4'b1011, 4'h5, 4'hA, 1'b1},  // R3 DA->A
    {4'b1011, 4'h7, 4'h8, 1'b0},  // R3 R6 A->AB hold
    {4'b1110, 4'h5, 4'hA, 1'b1},  // R3 reverse AB->A
    {4'b1110, 4'h1, 4'h2, 1'b0},  // R3 R5 A->DA
    {4'b1111, 4'h9, 4'h6, 1'b0},  // R3 DA->D
    {4'b1111, 4'hB, 4'h4, 1'b0},  // R3 R6 D->CD hold
    {4'b1001, 4'h9, 4'h6, 1'b0},  // R4 full fwd from CD -> D
    {4'b1010, 4'h1, 4'h2, 1'b0},  // R3 D->DA
    {4'b1100, 4'h9, 4'h6, 1'b0},  // R4 full rev from DA -> D
    {4'b1011, 4'hD, 4'h2, 1'b0},  // R6 D->DA hold
    {4'b1011, 4'h5, 4'hA, 1'b1},  // R3 DA->A
    {4'b1010, 4'h4, 4'h8, 1'b0},  // R5 A->AB
    {4'b1010, 4'h6, 4'h9, 1'b0},  // R3 AB->B
    {4'b1010, 4'h2, 4'h1, 1'b0},  // R5 B->BC
    {4'b1011, 4'hA, 4'h5, 1'b0},  // R3 BC->C
    {4'b1111, 4'hE, 4'h1, 1'b0},  // R6 C->BC hold
    {4'b0001, 4'h2, 4'h1, 1'b0},  // R7 R1 full mode, no step: hold ignored
    {4'b1001, 4'hA, 4'h5, 1'b0},  // R4 full fwd from BC -> C
    {4'b1001, 4'h9, 4'h6, 1'b0}   // R7 full C->D, hold ignored
  };

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [3:0] hx, input logic [3:0] lx,
                       input logic px);
    total++;
    if (hi_en !== hx || lo_en !== lx || home_pull !== px) begin
      bad++;
      $display("FAIL %s: hi=%b lo=%b home=%b expected hi=%b lo=%b home=%b",
               tag, hi_en, lo_en, home_pull, hx, lx, px);
    end
  endtask

  task automatic pulse_step();
    step_clk = 1'b1;
    wait_clk(8);
    step_clk = 1'b0;
    wait_clk(8);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_clk(4);
    // R11: reset state
    check("R11 reset", 4'h0, 4'h0, 1'b0);
    bias_ok = 1'b1;
    wait_clk(2);
    check("R11 held in reset", 4'h0, 4'h0, 1'b0);
    rst = 1'b0;
    wait_clk(10);
    check("R11 R8 home after reset", 4'h5, 4'hA, 1'b1);

    for (int v = 0; v < NV; v++) begin
      dir_rev   = VEC[v][11];
      half_mode = VEC[v][10];
      idle_hold = VEC[v][9];
      wait_clk(6);
      if (VEC[v][12]) pulse_step();
      else            wait_clk(16);
      check($sformatf("R1-table vector %0d", v), VEC[v][8:5], VEC[v][4:1], VEC[v][0]);
    end

    // R1: step_clk held high for a long time moves only once
    dir_rev = 1'b0; half_mode = 1'b0; idle_hold = 1'b0;
    wait_clk(6);
    step_clk = 1'b1;
    wait_clk(40);
    check("R1 long high one step", 4'h5, 4'hA, 1'b1);
    step_clk = 1'b0;
    wait_clk(8);

    // R9: loss of bias
    half_mode = 1'b1;
    wait_clk(6);
    pulse_step();
    check("R9 pre-loss AB", 4'h4, 4'h8, 1'b0);
    bias_ok = 1'b0;
    wait_clk(8);
    check("R9 drivers off", 4'h0, 4'h0, 1'b0);
    pulse_step();
    pulse_step();
    check("R9 steps ignored", 4'h0, 4'h0, 1'b0);
    bias_ok = 1'b1;
    wait_clk(8);
    check("R9 home on return", 4'h5, 4'hA, 1'b1);
    pulse_step();
    check("R9 step from home", 4'h4, 4'h8, 1'b0);

    // R11: reset mid-run returns home
    rst = 1'b1;
    wait_clk(3);
    check("R11 reset mid-run", 4'h0, 4'h0, 1'b0);
    rst = 1'b0;
    wait_clk(10);
    check("R11 home after second reset", 4'h5, 4'hA, 1'b1);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule